// File: doc/BRIEF.md
# Branch Delay-Slot Hazard Controller

This block is the stall and flush control for the branch delay slot in an in-order, seven-stage pipeline without exceptions. Every branch or jump in the instruction set has exactly one delay slot. The instruction in that slot executes whether or not the branch is taken. Branches are statically predicted not-taken, so fetch keeps going sequentially until the branch resolves in the execute stage. Stage numbering is fixed: 0 is fetch, 1 is decode, 2 is execute (where a branch resolves), and 3 to 6 follow. Bit `i` of `stall` and `flush` refers to stage `i`.

The controller keeps a small shadow of the pipeline registers for stages 1 to 6: a valid bit, a branch bit, a delay-slot tag and a taken-pending bit. The instruction accepted into decode right after a branch gets the tag. A RAW stall from the datapath can hold decode and put a bubble between a branch and its slot. So the controller keeps at most one branch/slot pair protected at a time. A newly decoded branch is held in decode while any tagged slot sits in stages 2 to 6. For a taken branch, the fetch redirect waits until the slot has moved past decode. The redirect then clears only the wrong-path instructions behind the slot.

Top module: `ds_hazard_ctrl`

## Requirements
- R1: After reset, every shadow valid bit and tag is clear. With all inputs low, `stall`, `flush` and `redirect` are all zero.
- R2: The instruction accepted into decode directly after a branch is that branch's delay slot. It is never flushed, and it retires as the next valid instruction after its branch.
- R3: While decode holds a valid branch and a tagged slot is present in any of stages 2 to 6, `stall[0]`, `stall[1]` and `flush[2]` are high in the same cycle.
- R4: `raw_stall` raises `stall[0]`, `stall[1]` and `flush[2]` in the same cycle. The fetch and decode contents are held, and stage 2 loads a bubble. The hold is the OR of this request and the R3 condition.
- R5: `ex_taken` is sampled only in a cycle where stage 2 holds a valid branch. Its value then decides whether that branch redirects.
- R6: `redirect` is high for exactly one cycle per taken branch. That cycle is the first one in which the branch has resolved taken and its slot occupies one of stages 2 to 6.
- R7: In a redirect cycle, `flush[0]`, `flush[1]` and `flush[2]` are high. The first instruction to retire after the slot of a taken branch comes from the redirected stream.
- R8: Stages 2 to 6 always advance: `stall[6:2]` and `flush[6:3]` are always zero.
- R9: A branch that resolves not-taken causes no redirect. The instruction that retires after its slot is the next one fetched in sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| if_valid | input | 1 | Fetch presents an instruction for decode |
| if_branch | input | 1 | The fetched instruction is a branch or jump |
| raw_stall | input | 1 | Datapath RAW / load-use hazard request: hold decode |
| ex_taken | input | 1 | Branch in stage 2 resolved taken |
| stall | output | 7 | Per-stage hold, bit i for stage i |
| flush | output | 7 | Per-stage bubble load, bit i for stage i (bit 0: drop fetch output) |
| redirect | output | 1 | Strobe: load the branch target into fetch |

## Verification
`stall`, `flush` and `redirect` are combinational on the shadow registers and the current inputs. They are therefore due in the same cycle as the condition that causes them. Their effect on the shadow state appears one edge later. A taken branch resolved at stage 2 redirects at the earliest on the next cycle, once its slot has been registered into stage 2. The bench drives inputs on the falling edge and samples outputs shortly after. It compares them with values predicted from its own model of the stages, then advances that model using the same edge rule. Retirement order and stream epochs are checked when an instruction leaves stage 6, five edges after it left decode.

// File: rtl/ds_hazard_ctrl.sv
module ds_hazard_ctrl #(
  parameter int NS = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          if_valid,
  input  logic          if_branch,
  input  logic          raw_stall,
  input  logic          ex_taken,
  output logic [NS-1:0] stall,
  output logic [NS-1:0] flush,
  output logic          redirect
);

  logic [NS-1:1] v, br, ds;
  logic [NS:3]   tk, fire;
  logic          last_br, hold, br_hold, accept, slot_br;

  assign br_hold  = v[1] & br[1] & (|ds[NS-1:2]);
  assign hold     = raw_stall | br_hold;
  assign redirect = |fire;
  assign accept   = if_valid & ~hold & ~redirect;
  assign stall    = {{(NS-2){1'b0}}, hold, hold};
  assign flush    = {{(NS-3){1'b0}}, hold | redirect, redirect, redirect};

  always_comb begin
    logic anyv, anyb;
    anyv = 1'b0;
    anyb = 1'b0;
    slot_br = 1'b0;
    fire = '0;
    for (int k = 3; k <= NS; k++) begin
      anyv = anyv | v[k-1];
      anyb = anyb | (v[k-1] & br[k-1]);
      fire[k] = tk[k] & anyv;
      slot_br = slot_br | (fire[k] & anyb);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v <= '0;
      br <= '0;
      ds <= '0;
      tk <= '0;
      last_br <= 1'b0;
    end else begin
      if (redirect) begin
        v[1] <= 1'b0;
        br[1] <= 1'b0;
        ds[1] <= 1'b0;
      end else if (!hold) begin
        v[1] <= if_valid;
        br[1] <= if_valid & if_branch;
        ds[1] <= if_valid & last_br;
      end

      if (redirect) last_br <= slot_br;
      else if (accept) last_br <= if_branch;

      if (hold | redirect) begin
        v[2] <= 1'b0;
        br[2] <= 1'b0;
        ds[2] <= 1'b0;
      end else begin
        v[2] <= v[1];
        br[2] <= br[1];
        ds[2] <= ds[1];
      end

      for (int k = 3; k < NS; k++) begin
        v[k] <= v[k-1];
        br[k] <= br[k-1];
        ds[k] <= ds[k-1];
      end

      tk[3] <= v[2] & br[2] & ex_taken;
      for (int k = 4; k < NS; k++) tk[k] <= tk[k-1] & ~fire[k-1];
      tk[NS] <= (tk[NS-1] & ~fire[NS-1]) | (tk[NS] & ~fire[NS]);
    end
  end

endmodule

// File: rtl/ds_hazard_ctrl_sva.sv
module ds_hazard_ctrl_sva #(
  parameter int NS = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NS-1:0] stall,
  input logic          redirect,
  input logic [NS-1:1] v,
  input logic [NS-1:1] br,
  input logic [NS-1:1] ds,
  input logic [NS:3]   tk
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (v == '0 && ds == '0 && tk == '0 && !redirect));

  assert_slot_not_in_decode_at_redirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> !ds[1]);

  assert_branch_waits_for_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (v[1] && br[1] && (ds[NS-1:2] != '0) && !redirect) |=> (v[1] && br[1]));

  assert_bubble_after_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall[1] && !redirect) |=> !v[2]);

  assert_single_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tk) <= 1);

  assert_redirect_clears_front_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (!v[1] && !v[2]));

endmodule

bind ds_hazard_ctrl ds_hazard_ctrl_sva #(.NS(NS)) u_sva (
  .clk(clk), .rst_n(rst_n), .stall(stall), .redirect(redirect),
  .v(v), .br(br), .ds(ds), .tk(tk)
);

// File: tb/ds_hazard_ctrl_bench.sv
module ds_hazard_ctrl_bench;
  localparam int NS = 7;
  localparam int CYC = 3000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic if_valid = 1'b0, if_branch = 1'b0, raw_stall = 1'b0, ex_taken = 1'b0;
  logic [NS-1:0] stall, flush;
  logic redirect;

  always #5 clk = ~clk;

  ds_hazard_ctrl #(.NS(NS)) u_ds_hazard_ctrl (
    .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_branch(if_branch),
    .raw_stall(raw_stall), .ex_taken(ex_taken), .stall(stall), .flush(flush),
    .redirect(redirect)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  bit a_br[4096], a_tk[4096], a_slot[4096];
  int a_ep[4096];
  bit m_v[NS];
  int m_s[NS];
  int seq = 0, epoch = 0, rp = -1, pend_s = 0, ntaken = 0, nred = 0, rawcnt = 0, nret = 0;
  bit pend = 0, prev_br = 0, prev_tk = 0, need_new = 1, cur_br = 0, cur_tk = 0, drain = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit dir_br(input int s);
    return (s == 0 || s == 1 || s == 4 || s == 7);
  endfunction

  function automatic bit dir_tk(input int s);
    return (s == 1 || s == 4);
  endfunction

  task automatic retire(input int r);
    nret++;
    if (rp >= 0) begin
      chk(r > rp, "R2", "retire order", r, rp + 1);
      if (a_br[rp]) chk(r == rp + 1, "R2", "slot follows branch", r, rp + 1);
      if (rp >= 1 && a_slot[rp] && a_br[rp-1]) begin
        if (a_tk[rp-1]) chk(a_ep[r] == a_ep[rp-1] + 1, "R7", "target-path epoch after slot", a_ep[r], a_ep[rp-1] + 1);
        else chk(r == rp + 1, "R9", "sequential after not-taken slot", r, rp + 1);
      end
    end
    rp = r;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < NS; i++) begin m_v[i] = 0; m_s[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk(stall == '0, "R1", "stall in reset", int'(stall), 0);
    chk(flush == '0, "R1", "flush in reset", int'(flush), 0);
    chk(redirect == 1'b0, "R1", "redirect in reset", int'(redirect), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(stall == '0 && flush == '0 && !redirect, "R1", "quiet after reset", int'(flush), 0);

    for (int cyc = 0; cyc < CYC + 20; cyc++) begin
      bit hold_e, red_e, slotback, hold_d, red_d, acc;
      logic [NS-1:0] st_e, fl_e;
      @(negedge clk);
      drain = (cyc >= CYC);
      if (need_new) begin
        if (seq < 8) begin cur_br = dir_br(seq); cur_tk = dir_tk(seq); end
        else begin
          cur_br = (($urandom % 100) < 30) && !prev_tk;
          cur_tk = $urandom % 2;
        end
        need_new = 0;
      end
      if_valid = drain ? 1'b0 : (seq < 8 ? 1'b1 : (($urandom % 100) < 90));
      if_branch = cur_br;
      ex_taken = m_v[2] && a_br[m_s[2]] && a_tk[m_s[2]];
      if (m_v[1] && m_s[1] == 5 && rawcnt < 2) begin raw_stall = 1'b1; rawcnt++; end
      else raw_stall = (seq >= 8) && !drain && (($urandom % 100) < 15);
      #1;
      slotback = 0;
      red_e = 0;
      for (int i = 2; i < NS; i++) begin
        if (m_v[i] && a_slot[m_s[i]]) slotback = 1;
        if (pend && m_v[i] && m_s[i] == pend_s + 1) red_e = 1;
      end
      hold_e = raw_stall || (m_v[1] && a_br[m_s[1]] && slotback);
      st_e = '0; st_e[0] = hold_e; st_e[1] = hold_e;
      fl_e = '0; fl_e[0] = red_e; fl_e[1] = red_e; fl_e[2] = hold_e || red_e;
      chk(stall[1:0] == st_e[1:0], (raw_stall ? "R4" : "R3"), "front stall", int'(stall), int'(st_e));
      chk(stall[NS-1:2] == '0 && flush[NS-1:3] == '0, "R8", "back stages free", int'(flush), int'(fl_e));
      chk(redirect == red_e, (red_e ? "R6" : "R9"), "redirect", int'(redirect), int'(red_e));
      chk(flush[2:0] == fl_e[2:0], (red_e ? "R7" : "R3"), "flush", int'(flush), int'(fl_e));

      hold_d = stall[1];
      red_d = redirect;
      acc = if_valid && !hold_d && !red_d;
      if (m_v[NS-1]) retire(m_s[NS-1]);
      if (red_d) begin pend = 0; nred++; end
      if (ex_taken) begin pend = 1; pend_s = m_s[2]; ntaken++; end
      for (int i = NS - 1; i >= 3; i--) begin m_v[i] = m_v[i-1]; m_s[i] = m_s[i-1]; end
      m_v[2] = (hold_d || red_d) ? 1'b0 : m_v[1];
      m_s[2] = m_s[1];
      if (red_d) m_v[1] = 0;
      else if (!hold_d) begin
        m_v[1] = acc;
        if (acc) begin
          a_br[seq] = cur_br; a_tk[seq] = cur_tk; a_ep[seq] = epoch; a_slot[seq] = prev_br;
          prev_br = cur_br; prev_tk = cur_br && cur_tk;
          m_s[1] = seq;
          seq++;
          need_new = 1;
        end
      end
      if (red_d) begin epoch++; prev_br = 0; prev_tk = 0; need_new = 1; end
    end
    chk(nred == ntaken, "R6", "one redirect per taken branch", nred, ntaken);
    chk(nret > 100, "R5", "instructions retired", nret, 101);
    chk(!pend, "R6", "no redirect left pending", int'(pend), 0);
    finish_run();
  end
endmodule